// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that takes one clock cycle for each instruction. In every cycle it places the program counter on an instruction port and decodes the word that comes back. It reads two source registers and computes a result in an ALU. It may read or write one data word, and at the closing clock edge it commits both the register write and the next program counter. The core executes six operations: unsigned add, unsigned subtract, OR with an immediate, load word, store word and branch on equal.

Both memories are outside the core. The instruction port is read combinationally. The data port is read combinationally and written on the clock edge. The surrounding system, here the testbench, supplies the storage behind both ports. A small decoder turns the opcode and function fields into control points. Those control points select the destination field, the second ALU operand, the immediate extension mode and the write-back source.

Top module: `sc_core`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, the program counter becomes 0, and `dmem_we` stays low throughout reset.
- R2: When an instruction is not a taken branch, the program counter at the next edge equals the current one plus 4.
- R3: ADDU (opcode 000000, funct 100001, destination in bits [15:11]) writes the 32-bit sum of the registers named by bits [25:21] and [20:16].
- R4: SUBU (opcode 000000, funct 100011) writes the first source minus the second, wrapping modulo 2^32, into the register named by bits [15:11].
- R5: ORI (opcode 001101) writes the OR of the source register and the zero-extended bits [15:0] into the register named by bits [20:16].
- R6: LW (opcode 100011) loads the word read at the address (source register + sign-extended bits [15:0]) into the register named by bits [20:16].
- R7: SW (opcode 101011) raises `dmem_we` for one cycle. It drives the address (source register + sign-extended bits [15:0]) and, as data, the register named by bits [20:16]. No other instruction raises `dmem_we`.
- R8: BEQ (opcode 000100) sets the next program counter to PC+4 + (sign-extended bits [15:0] shifted left by 2) when the two registers are equal, and to PC+4 otherwise.
- R9: Register 0 always reads as zero. A write aimed at it is dropped.
- R10: Any opcode other than the six above, and any register-format funct other than 100001 or 100011, writes no register and no memory and advances the PC by 4.
- R11: A register written at an edge is read with its new value by the instruction of the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word read combinationally at `imem_addr` |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; the word is written at the next rising edge |
| dmem_rdata | input | 32 | Load data read combinationally at `dmem_addr` |

## Verification
A register write and a read of that same register by the following instruction meet at a single clock edge. The write is committed at the edge that closes one cycle, and the read is combinational in the cycle that opens right after it. The bench provokes this with chains that have no gap between dependent instructions: ORI feeding ADDU, then SUBU, a load followed at once by a store of the loaded register, and a branch that compares registers written just before it. It judges the result only through the values and addresses that later stores put on the data port, and through the PC trace on the instruction port.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    src_is_imm;
        logic    imm_signed;
        logic    wb_from_mem;
        logic    reg_we;
        logic    mem_we;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;

    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] OPC_ORI  = 6'b001101;
    localparam logic [5:0] OPC_LOAD = 6'b100011;
    localparam logic [5:0] OPC_STOR = 6'b101011;
    localparam logic [5:0] OPC_BEQ  = 6'b000100;
    localparam logic [5:0] FN_ADDU  = 6'b100001;
    localparam logic [5:0] FN_SUBU  = 6'b100011;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o = '{dst_is_rd: 1'b0, src_is_imm: 1'b0, imm_signed: 1'b0,
                   wb_from_mem: 1'b0, reg_we: 1'b0, mem_we: 1'b0,
                   is_branch: 1'b0, alu_op: ALU_ADD};
        case (opcode_i)
            OPC_REG: begin
                ctrl_o.dst_is_rd = 1'b1;
                if (funct_i == FN_ADDU) begin
                    ctrl_o.reg_we = 1'b1;
                    ctrl_o.alu_op = ALU_ADD;
                end else if (funct_i == FN_SUBU) begin
                    ctrl_o.reg_we = 1'b1;
                    ctrl_o.alu_op = ALU_SUB;
                end
            end
            OPC_ORI: begin
                ctrl_o.src_is_imm = 1'b1;
                ctrl_o.reg_we     = 1'b1;
                ctrl_o.alu_op     = ALU_OR;
            end
            OPC_LOAD: begin
                ctrl_o.src_is_imm  = 1'b1;
                ctrl_o.imm_signed  = 1'b1;
                ctrl_o.wb_from_mem = 1'b1;
                ctrl_o.reg_we      = 1'b1;
            end
            OPC_STOR: begin
                ctrl_o.src_is_imm = 1'b1;
                ctrl_o.imm_signed = 1'b1;
                ctrl_o.mem_we     = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_o.imm_signed = 1'b1;
                ctrl_o.is_branch  = 1'b1;
                ctrl_o.alu_op     = ALU_SUB;
            end
            default: ;
        endcase
    end

    always_comb begin
        if (!(opcode_i inside {OPC_REG, OPC_ORI, OPC_LOAD, OPC_STOR, OPC_BEQ}))
            AST_UNKNOWN_NO_WRITE: assert (!ctrl_o.reg_we && !ctrl_o.mem_we); // R10
        if (opcode_i == OPC_REG && !(funct_i inside {FN_ADDU, FN_SUBU}))
            AST_BAD_FUNCT_NO_WRITE: assert (!ctrl_o.reg_we); // R10
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] y_o,
    output logic             zero_o
);

    always_comb begin
        case (op_i)
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_OR:  y_o = a_i | b_i;
            default: y_o = '0;
        endcase
        zero_o = (y_o == '0);
    end

    always_comb begin
        if (op_i == ALU_SUB)
            AST_ZERO_MEANS_EQUAL: assert (zero_o == (a_i == b_i)); // R8
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    ra_i,
    input  logic [AW-1:0]    rb_i,
    output logic [WIDTH-1:0] da_o,
    output logic [WIDTH-1:0] db_o,
    input  logic             we_i,
    input  logic [AW-1:0]    wa_i,
    input  logic [WIDTH-1:0] wd_i
);

    logic [WIDTH-1:0] regs_d [DEPTH];
    logic [WIDTH-1:0] regs_q [DEPTH];

    always_comb begin
        regs_d = regs_q;
        if (we_i && wa_i != '0)
            regs_d[wa_i] = wd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign da_o = (ra_i == '0) ? '0 : regs_q[ra_i];
    assign db_o = (rb_i == '0) ? '0 : regs_q[rb_i];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (we_i && wa_i != '0) |=> (regs_q[$past(wa_i)] == $past(wd_i))); // R11

    AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
        (ra_i == '0) |-> (da_o == '0)); // R9

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 32,
    localparam int unsigned RAW  = $clog2(NREGS)
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t st_d, st_q;

    logic [5:0]      opcode, funct;
    logic [RAW-1:0]  rs_f, rt_f, rd_f, dst;
    logic [15:0]     imm16;
    logic [XLEN-1:0] imm_ext, bus_a, bus_b, alu_b, alu_y, wb_val;
    logic [XLEN-1:0] pc_plus4, br_target;
    logic            alu_zero, take_br;
    ctrl_t           ctl;

    assign opcode = imem_data[31:26];
    assign rs_f   = imem_data[25:21];
    assign rt_f   = imem_data[20:16];
    assign rd_f   = imem_data[15:11];
    assign funct  = imem_data[5:0];
    assign imm16  = imem_data[15:0];

    sc_decode u_dec (
        .opcode_i (opcode),
        .funct_i  (funct),
        .ctrl_o   (ctl)
    );

    sc_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_i (rs_f),
        .rb_i (rt_f),
        .da_o (bus_a),
        .db_o (bus_b),
        .we_i (ctl.reg_we),
        .wa_i (dst),
        .wd_i (wb_val)
    );

    always_comb begin
        imm_ext = ctl.imm_signed ? {{(XLEN-16){imm16[15]}}, imm16}
                                 : {{(XLEN-16){1'b0}}, imm16};
        alu_b   = ctl.src_is_imm ? imm_ext : bus_b;
        dst     = ctl.dst_is_rd ? rd_f : rt_f;
        wb_val  = ctl.wb_from_mem ? dmem_rdata : alu_y;
    end

    sc_alu #(.WIDTH(XLEN)) u_alu (
        .op_i   (ctl.alu_op),
        .a_i    (bus_a),
        .b_i    (alu_b),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    always_comb begin
        pc_plus4  = st_q.pc + XLEN'(4);
        br_target = pc_plus4 + (imm_ext << 2);
        take_br   = ctl.is_branch && alu_zero;
        st_d      = st_q;
        st_d.pc   = take_br ? br_target : pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = bus_b;
    assign dmem_we    = ctl.mem_we & ~rst;

    AST_RESET_PC: assert property (@(posedge clk)
        rst |=> (imem_addr == '0)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> (imem_addr == $past(imem_addr) + 32'd4)); // R2

    AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (imem_addr == $past(imem_addr) + 32'd4 + ($past(imem_ext_w) << 2))); // R8

    logic [XLEN-1:0] imem_ext_w;
    assign imem_ext_w = {{(XLEN-16){imem_data[15]}}, imem_data[15:0]};

    AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (opcode == OPC_STOR)); // R7

endmodule

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [32];
    logic [31:0] dmem [32];

    always #2.5 clk = ~clk;

    sc_core i_sc_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[6:2]];
    assign dmem_rdata = dmem[dmem_addr[6:2]];

    always @(posedge clk)
        if (dmem_we) dmem[dmem_addr[6:2]] <= dmem_wdata;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } store_t;

    store_t      sq[$];
    logic [31:0] pq[$];
    int          checks = 0;
    int          errors = 0;
    bit          running = 0;
    bit          done = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    task automatic push_store(input logic [31:0] a, input logic [31:0] d, input string tag);
        store_t s;
        s.addr = a; s.data = d; s.tag = tag;
        sq.push_back(s);
    endtask

    // monitor: compares PC trace and every store against the scoreboard
    always @(negedge clk) begin
        if (running) begin
            if (pq.size() > 0) begin
                logic [31:0] e;
                e = pq.pop_front();
                check(imem_addr == e, "R2 R8 pc", imem_addr, e);
            end
            if (dmem_we) begin
                if (sq.size() == 0) begin
                    check(1'b0, "R7 R10 unexpected store", dmem_addr, 32'hxxxxxxxx);
                end else begin
                    store_t s;
                    s = sq.pop_front();
                    check(dmem_addr == s.addr, {s.tag, " addr"}, dmem_addr, s.addr);
                    check(dmem_wdata == s.data, {s.tag, " data"}, dmem_wdata, s.data);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
        dmem[7] = 32'hCAFEF00D;

        imem[0]  = enc_i(6'h0D, 0, 1, 16'h8005);  // ori r1
        imem[1]  = enc_i(6'h0D, 0, 2, 16'h0003);  // ori r2
        imem[2]  = enc_r(1, 2, 3, 6'h21);         // addu r3
        imem[3]  = enc_r(2, 1, 4, 6'h23);         // subu r4
        imem[4]  = enc_i(6'h2B, 0, 3, 16'h0000);  // sw r3,0
        imem[5]  = enc_i(6'h2B, 0, 4, 16'h0004);  // sw r4,4
        imem[6]  = enc_i(6'h0D, 0, 0, 16'h1234);  // ori r0 (dropped)
        imem[7]  = enc_i(6'h2B, 0, 0, 16'h0008);  // sw r0,8
        imem[8]  = enc_i(6'h23, 0, 5, 16'h0004);  // lw r5,4
        imem[9]  = enc_i(6'h2B, 0, 5, 16'h000C);  // sw r5,12
        imem[10] = enc_i(6'h0D, 0, 6, 16'h0020);  // ori r6
        imem[11] = enc_i(6'h23, 6, 7, 16'hFFFC);  // lw r7,-4(r6)
        imem[12] = enc_i(6'h2B, 6, 7, 16'hFFF8);  // sw r7,-8(r6)
        imem[13] = enc_i(6'h04, 2, 2, 16'h0001);  // beq taken
        imem[14] = enc_i(6'h2B, 0, 1, 16'h0040);  // skipped store
        imem[15] = enc_i(6'h04, 1, 2, 16'h0005);  // beq not taken
        imem[16] = enc_i(6'h2B, 0, 2, 16'h0044);  // sw r2
        imem[17] = 32'hFFFFFFFF;                  // unknown opcode
        imem[18] = enc_r(2, 1, 3, 6'h20);         // unknown funct
        imem[19] = enc_i(6'h2B, 0, 31, 16'h0048); // sw r31
        imem[20] = enc_i(6'h2B, 0, 3, 16'h004C);  // sw r3
        imem[21] = enc_i(6'h04, 0, 0, 16'hFFFF);  // beq to itself

        for (int i = 0; i <= 13; i++) pq.push_back(32'(i * 4));
        for (int i = 15; i <= 21; i++) pq.push_back(32'(i * 4));
        for (int i = 0; i < 3; i++) pq.push_back(32'h54);

        push_store(32'h00, 32'h00008008, "R3 R5 R11 addu");
        push_store(32'h04, 32'hFFFF7FFE, "R4 subu");
        push_store(32'h08, 32'h00000000, "R9 r0");
        push_store(32'h0C, 32'hFFFF7FFE, "R6 lw");
        push_store(32'h18, 32'hCAFEF00D, "R6 R7 negative offset");
        push_store(32'h44, 32'h00000003, "R8 not taken");
        push_store(32'h48, 32'h00000000, "R10 unknown opcode");
        push_store(32'h4C, 32'h00008008, "R10 unknown funct");

        repeat (3) @(negedge clk);
        check(imem_addr == 32'h0, "R1 reset pc", imem_addr, 32'h0);
        check(dmem_we == 1'b0, "R1 reset no store", {31'b0, dmem_we}, 32'h0);
        @(posedge clk);
        #1 rst = 1'b0;
        running = 1'b1;
        repeat (30) @(negedge clk);
        running = 1'b0;
        check(sq.size() == 0, "R7 stores missing", sq.size(), 0);
        check(pq.size() == 0, "R8 pc trace left", pq.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule